// File: doc/BRIEF.md
# Two-Bank USB IN Endpoint Transmit Buffer

This block buffers outgoing payloads for one IN endpoint of a USB device controller. It has two payload banks. The processor fills one bank while the serial engine sends the other. The processor pushes bytes one at a time into the bank selected for writing. A strobe then marks that bank as ready, and the write selection moves to the other bank. Another strobe clears the completion flag.

On the serial side, the engine raises an IN token strobe. The block answers one cycle later with either a data response or a NAK. The data response carries the bank's byte count. The engine then pulls the payload byte by byte. The host outcome comes back as an ACK strobe or a timeout strobe. An ACK frees the bank and raises the completion flag, which also drives the interrupt. A timeout keeps the bank loaded and rewinds it, so the next token resends the same bytes.

PID generation, CRC, bit stuffing, data toggle and the line interface belong to other blocks.

Top module: `usb_in_pingpong`

## Requirements
- R1: After reset both banks are empty, write selection and send selection are bank 0, and the ready status, completion flag, interrupt and both response strobes are 0.
- R2: Bytes written while the write bank is not loaded are stored in order. When that bank is sent, the same bytes are read back in the same order on `rd_byte`.
- R3: A `cpu_set_rdy` strobe while the write bank is free marks that bank loaded and toggles `wr_bank` (0 to 1 to 0). The processor may start writing the other bank in the very next cycle.
- R4: Banks are sent in the order they were loaded. `tx_bank` toggles only when a sent bank is acknowledged.
- R5: An IN token while the send bank is not loaded yields `rsp_nak`=1 and `rsp_data`=0 in the cycle after the token.
- R6: An IN token while the send bank is loaded yields `rsp_data`=1 and `rsp_nak`=0 in the cycle after the token, with `rsp_len` equal to the bank's byte count. A count of 0 gives a zero-length packet.
- R7: A `host_ack` while awaiting the handshake frees the sent bank and sets `cpu_done` in the next cycle.
- R8: `irq` is 1 exactly while `cpu_done` is 1. The flag holds until `cpu_clr_done`. If an ACK arrives in the same cycle as a clear, the ACK wins.
- R9: Clearing the completion flag after setting ready for the next bank leaves that bank loaded, and it is sent next.
- R10: A `host_tmo` instead of an ACK keeps the bank loaded and rewinds its read position. The next IN token resends the same length and bytes from the first one.
- R11: `cpu_rdy_stat` is 1 whenever the bank selected for writing is still loaded. Byte writes and ready strobes in that state are ignored.
- R12: Each bank holds at most `BANK_BYTES` bytes. Further writes to a full bank are ignored and the count stays at `BANK_BYTES`.
- R13: `rd_last` is 1 while `rd_byte` shows the final byte of a non-empty packet. Reads beyond the count do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | Processor byte write strobe |
| cpu_wr_data | input | DATA_W | Processor byte to store |
| cpu_set_rdy | input | 1 | Processor marks the write bank loaded |
| cpu_clr_done | input | 1 | Processor clears the completion flag |
| cpu_rdy_stat | output | 1 | Write bank still loaded |
| cpu_done | output | 1 | Transfer-complete flag |
| irq | output | 1 | Completion interrupt |
| wr_bank | output | 1 | Bank selected for processor writes |
| tx_bank | output | 1 | Bank selected for sending |
| tok_in | input | 1 | IN token received |
| rsp_data | output | 1 | Token answered with a data packet |
| rsp_nak | output | 1 | Token answered with NAK |
| rsp_len | output | $clog2(BANK_BYTES+1) | Byte count of the packet being sent |
| rd_en | input | 1 | Serial engine consumes the current byte |
| rd_byte | output | DATA_W | Current payload byte |
| rd_last | output | 1 | Current byte is the final one |
| host_ack | input | 1 | Host acknowledged the packet |
| host_tmo | input | 1 | Handshake timed out |

## Verification
The bench builds the block with its defaults, 64-byte banks of 8-bit data. At that size, overflowing a full bank costs only 70 writes, so the saturation rule is hit directly. The random phase also reaches lengths from zero to the full bank on both sides of the ping-pong. Random mixes of writes, ready strobes, clears, tokens, partial reads followed by timeouts, and acknowledged sends are checked against a bench model of both banks. That mix reaches the both-banks-loaded state, resends after rewind, and clears that follow a new ready strobe.

// File: rtl/pp_pkg.sv
package pp_pkg;
   typedef enum logic {
      TXS_IDLE  = 1'b0,
      TXS_AWAIT = 1'b1
   } txs_e;
endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
   parameter  int DEPTH = 64,
   parameter  int DW    = 8,
   localparam int CW    = $clog2(DEPTH + 1),
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          clr,
   input  logic [CW-1:0] rd_ptr,
   output logic [DW-1:0] rd_data,
   output logic [CW-1:0] cnt
);
   logic [DW-1:0] mem [DEPTH];
   logic          room;

   assign room = (cnt < CW'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clr)            cnt <= '0;
      else if (wr_en && room)  cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en && !clr && room) mem[cnt[AW-1:0]] <= wr_data;
   end

   assign rd_data = mem[rd_ptr[AW-1:0]];

   // R12: a write into a full bank leaves the count unchanged
   a_r12_full_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr && cnt == CW'(DEPTH)) |=> $stable(cnt));
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
   import pp_pkg::*;
#(
   parameter  int DEPTH = 64,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_rdy,
   input  logic          clr_done,
   input  logic          tok_in,
   input  logic          rd_en,
   input  logic          host_ack,
   input  logic          host_tmo,
   input  logic [CW-1:0] tx_cnt,
   output logic [1:0]    loaded,
   output logic          wr_bank,
   output logic          tx_bank,
   output logic [CW-1:0] rd_ptr,
   output logic          done,
   output logic          rsp_data,
   output logic          rsp_nak,
   output logic [CW-1:0] rsp_len,
   output logic          rd_last,
   output logic [1:0]    rel
);
   txs_e st;
   logic set_ok, ack_ok, tmo_ok, tok_ok, rd_ok, tx_ld;
   logic [1:0] ld_nxt;

   assign tx_ld  = loaded[tx_bank];
   assign set_ok = set_rdy && !loaded[wr_bank];
   assign ack_ok = host_ack && (st == TXS_AWAIT);
   assign tmo_ok = host_tmo && !host_ack && (st == TXS_AWAIT);
   assign tok_ok = tok_in && (st == TXS_IDLE);
   assign rd_ok  = rd_en && (st == TXS_AWAIT) && (rd_ptr < tx_cnt);

   for (genvar g = 0; g < 2; g++) begin : g_rel
      assign rel[g] = ack_ok && (tx_bank == 1'(g));
   end

   always_comb begin
      ld_nxt = loaded;
      if (set_ok) ld_nxt[wr_bank] = 1'b1;
      if (ack_ok) ld_nxt[tx_bank] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loaded   <= '0;
         wr_bank  <= 1'b0;
         tx_bank  <= 1'b0;
         st       <= TXS_IDLE;
         rd_ptr   <= '0;
         done     <= 1'b0;
         rsp_data <= 1'b0;
         rsp_nak  <= 1'b0;
         rsp_len  <= '0;
      end else begin
         loaded   <= ld_nxt;
         rsp_data <= tok_ok && tx_ld;
         rsp_nak  <= tok_ok && !tx_ld;
         if (set_ok) wr_bank <= ~wr_bank;
         if (ack_ok) tx_bank <= ~tx_bank;
         if (ack_ok)        done <= 1'b1;
         else if (clr_done) done <= 1'b0;
         if (tok_ok) rsp_len <= tx_ld ? tx_cnt : '0;
         if (tok_ok || ack_ok || tmo_ok) rd_ptr <= '0;
         else if (rd_ok)                 rd_ptr <= rd_ptr + 1'b1;
         case (st)
            TXS_IDLE:  if (tok_ok && tx_ld)   st <= TXS_AWAIT;
            TXS_AWAIT: if (ack_ok || tmo_ok) st <= TXS_IDLE;
            default:                         st <= TXS_IDLE;
         endcase
      end
   end

   assign rd_last = (st == TXS_AWAIT) && (tx_cnt != '0) && (rd_ptr == tx_cnt - 1'b1);

   // R5: empty send bank answers with NAK only
   a_r5_nak_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_in && st == TXS_IDLE && !loaded[tx_bank]) |=> (rsp_nak && !rsp_data));
   // R6: data and NAK responses are exclusive
   a_r6_resp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_data && rsp_nak));
   // R7: an accepted ACK raises the completion flag
   a_r7_ack_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
      (host_ack && st == TXS_AWAIT) |=> done);
   // R8: completion flag holds until cleared
   a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr_done) |=> done);
   // R10: timeout keeps the bank and rewinds
   a_r10_tmo_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
      (host_tmo && !host_ack && st == TXS_AWAIT) |=> (loaded[$past(tx_bank)] && rd_ptr == '0));
   // R11: ready strobe on a loaded write bank does not move the selection
   a_r11_set_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (set_rdy && loaded[wr_bank]) |=> $stable(wr_bank));
endmodule

// File: rtl/usb_in_pingpong.sv
module usb_in_pingpong #(
   parameter  int BANK_BYTES = 64,
   parameter  int DATA_W     = 8,
   localparam int CW         = $clog2(BANK_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr_en,
   input  logic [DATA_W-1:0] cpu_wr_data,
   input  logic              cpu_set_rdy,
   input  logic              cpu_clr_done,
   output logic              cpu_rdy_stat,
   output logic              cpu_done,
   output logic              irq,
   output logic              wr_bank,
   output logic              tx_bank,
   input  logic              tok_in,
   output logic              rsp_data,
   output logic              rsp_nak,
   output logic [CW-1:0]     rsp_len,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_byte,
   output logic              rd_last,
   input  logic              host_ack,
   input  logic              host_tmo
);
   if (BANK_BYTES < 1 || BANK_BYTES > 1023) begin : g_bad_depth
      $error("usb_in_pingpong: BANK_BYTES out of range");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("usb_in_pingpong: DATA_W must be positive");
   end

   logic [1:0]        loaded, rel, bank_we;
   logic [CW-1:0]     rd_ptr;
   logic [CW-1:0]     cnt_b [2];
   logic [DATA_W-1:0] rdat_b [2];

   for (genvar g = 0; g < 2; g++) begin : g_bank
      assign bank_we[g] = cpu_wr_en && (wr_bank == 1'(g)) && !loaded[g];
      pp_bank #(.DEPTH(BANK_BYTES), .DW(DATA_W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (bank_we[g]),
         .wr_data (cpu_wr_data),
         .clr     (rel[g]),
         .rd_ptr  (rd_ptr),
         .rd_data (rdat_b[g]),
         .cnt     (cnt_b[g])
      );
   end

   pp_ctrl #(.DEPTH(BANK_BYTES)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_rdy  (cpu_set_rdy),
      .clr_done (cpu_clr_done),
      .tok_in   (tok_in),
      .rd_en    (rd_en),
      .host_ack (host_ack),
      .host_tmo (host_tmo),
      .tx_cnt   (cnt_b[tx_bank]),
      .loaded   (loaded),
      .wr_bank  (wr_bank),
      .tx_bank  (tx_bank),
      .rd_ptr   (rd_ptr),
      .done     (cpu_done),
      .rsp_data (rsp_data),
      .rsp_nak  (rsp_nak),
      .rsp_len  (rsp_len),
      .rd_last  (rd_last),
      .rel      (rel)
   );

   assign rd_byte      = rdat_b[tx_bank];
   assign cpu_rdy_stat = loaded[wr_bank];
   assign irq          = cpu_done;

   // R11: writes while both banks are loaded change no count
   a_r11_wr_ignored_full: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr_en && loaded == 2'b11 && !host_ack) |=> ($stable(cnt_b[0]) && $stable(cnt_b[1])));
   // R4: the send selection moves only on a bank release
   a_r4_tx_moves_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      (rel == 2'b00) |=> $stable(tx_bank));
endmodule

// File: tb/usb_in_pingpong_tb.sv
`timescale 1ns/1ps
module usb_in_pingpong_tb;
   localparam int BB = 64;
   localparam int CW = $clog2(BB + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_wr_en = 1'b0, cpu_set_rdy = 1'b0, cpu_clr_done = 1'b0;
   logic [7:0] cpu_wr_data = '0;
   logic tok_in = 1'b0, rd_en = 1'b0, host_ack = 1'b0, host_tmo = 1'b0;
   logic cpu_rdy_stat, cpu_done, irq, wr_bank, tx_bank, rsp_data, rsp_nak, rd_last;
   logic [CW-1:0] rsp_len;
   logic [7:0] rd_byte;

   int n_chk = 0, n_fail = 0;
   logic [7:0] mbuf [2][BB];
   int  mcnt [2];
   bit  mload [2];
   bit  mwb, mtb, mdone;

   always #4 clk = ~clk;

   usb_in_pingpong #(.BANK_BYTES(BB), .DATA_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
      .cpu_set_rdy(cpu_set_rdy), .cpu_clr_done(cpu_clr_done), .cpu_rdy_stat(cpu_rdy_stat),
      .cpu_done(cpu_done), .irq(irq), .wr_bank(wr_bank), .tx_bank(tx_bank),
      .tok_in(tok_in), .rsp_data(rsp_data), .rsp_nak(rsp_nak), .rsp_len(rsp_len),
      .rd_en(rd_en), .rd_byte(rd_byte), .rd_last(rd_last),
      .host_ack(host_ack), .host_tmo(host_tmo));

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic bit exp_rdy();
      return mload[mwb];
   endfunction

   task automatic check_status();
      chk("R11 ready status", 32'(cpu_rdy_stat), 32'(exp_rdy()));
      chk("R3 write bank", 32'(wr_bank), 32'(mwb));
      chk("R4 send bank", 32'(tx_bank), 32'(mtb));
      chk("R7 done flag", 32'(cpu_done), 32'(mdone));
      chk("R8 irq", 32'(irq), 32'(mdone));
   endtask

   task automatic cpu_write(input logic [7:0] b);
      cpu_wr_en = 1'b1; cpu_wr_data = b;
      tick();
      cpu_wr_en = 1'b0;
      if (!mload[mwb] && mcnt[mwb] < BB) begin
         mbuf[mwb][mcnt[mwb]] = b;
         mcnt[mwb]++;
      end
   endtask

   task automatic cpu_set();
      cpu_set_rdy = 1'b1;
      tick();
      cpu_set_rdy = 1'b0;
      if (!mload[mwb]) begin
         mload[mwb] = 1'b1;
         mwb = ~mwb;
      end
   endtask

   task automatic cpu_clr();
      cpu_clr_done = 1'b1;
      tick();
      cpu_clr_done = 1'b0;
      mdone = 1'b0;
   endtask

   task automatic serve(input bit ack, input int nread);
      int n;
      tok_in = 1'b1;
      tick();
      tok_in = 1'b0;
      if (mload[mtb]) begin
         chk("R6 data response", 32'(rsp_data), 32'd1);
         chk("R6 no NAK", 32'(rsp_nak), 32'd0);
         chk("R6 length", 32'(rsp_len), 32'(mcnt[mtb]));
         n = (nread < mcnt[mtb]) ? nread : mcnt[mtb];
         for (int i = 0; i < n; i++) begin
            chk("R2 payload byte", 32'(rd_byte), 32'(mbuf[mtb][i]));
            chk("R13 last marker", 32'(rd_last), 32'(i == mcnt[mtb] - 1));
            rd_en = 1'b1;
            tick();
         end
         rd_en = 1'b0;
         if (ack) begin
            host_ack = 1'b1; tick(); host_ack = 1'b0;
            mload[mtb] = 1'b0; mcnt[mtb] = 0; mtb = ~mtb; mdone = 1'b1;
         end else begin
            host_tmo = 1'b1; tick(); host_tmo = 1'b0;
         end
      end else begin
         chk("R5 NAK response", 32'(rsp_nak), 32'd1);
         chk("R5 no data", 32'(rsp_data), 32'd0);
      end
      check_status();
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int r;
      void'($urandom(32'd20240611));
      mcnt[0] = 0; mcnt[1] = 0; mload[0] = 0; mload[1] = 0;
      mwb = 0; mtb = 0; mdone = 0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      check_status();
      chk("R1 no data response", 32'(rsp_data), 32'd0);
      chk("R1 no NAK", 32'(rsp_nak), 32'd0);

      // R5 token with nothing loaded
      serve(1'b1, 0);

      // R6 zero-length packet, R8 irq holds
      cpu_set();
      check_status();
      serve(1'b1, 0);
      repeat (3) tick();
      chk("R8 irq held", 32'(irq), 32'd1);
      cpu_clr();
      check_status();

      // R12 overflow of bank 1, R3 immediate fill of bank 0
      for (int i = 0; i < 70; i++) cpu_write(8'(i * 3 + 1));
      cpu_set();
      for (int i = 0; i < 3; i++) cpu_write(8'(8'hA0 + i));
      cpu_set();
      check_status();
      // R11 both loaded: write and ready strobe ignored
      cpu_write(8'hEE);
      cpu_set();
      check_status();

      // R10 partial read then timeout, resent afterwards
      serve(1'b0, 5);
      serve(1'b1, BB);
      // R9 set ready for next bank, then clear done
      cpu_write(8'h55);
      cpu_write(8'h66);
      cpu_set();
      cpu_clr();
      check_status();
      serve(1'b1, BB);
      serve(1'b1, BB);
      serve(1'b1, 0);
      cpu_clr();

      // random phase
      for (int k = 0; k < 600; k++) begin
         r = int'($urandom % 10);
         if (r < 5)       cpu_write(8'($urandom));
         else if (r < 7)  cpu_set();
         else if (r == 7) cpu_clr();
         else             serve(($urandom % 4) != 0, int'($urandom % 70));
         check_status();
      end
      finish_run();
   end
endmodule